// File: doc/BRIEF.md
# DMA Transfer Address and Count Engine

This block is the per-channel datapath of a DMA channel. Software programs a 16-bit starting address, a 16-bit count and an 8-bit page value. The engine then turns each accepted transfer into a 24-bit physical memory address inside the lower 16 MB. After each transfer it steps its address and count, and it raises a one-cycle terminal-count pulse when the programmed run is complete. The page value never changes during a run. The address counter therefore wraps inside a fixed window: 64 KB for a byte channel, 128 KB for a word channel.

A parameter picks the channel kind. On a byte channel the page forms the upper eight address bits and the counter forms the lower sixteen. On a word channel the whole mapping moves up by one bit. Page bit 0 is then ignored, physical bit 0 is always zero, and each transfer moves one 16-bit word.

Transfers arrive on a valid/ready handshake. `xfer_ready` is high while a programmed run is in progress. It does not depend on `xfer_valid`. A requester holds `xfer_valid` until it sees `xfer_ready`, and a transfer is accepted in every cycle where both are high. The physical address and byte lanes shown while `xfer_valid` is high belong to the transfer that will be accepted.

Top module: `dma_xfer_engine`

## Requirements
- R1: On a byte channel (`CHAN_KIND` = CHAN_BYTE), `phys_addr` equals {page[7:0], address[15:0]}.
- R2: On a word channel (`CHAN_KIND` = CHAN_WORD), `phys_addr` equals {page[7:1], address[15:0], 1'b0}, and programmed page bit 0 has no effect on it.
- R3: Each accepted transfer (`xfer_valid` and `xfer_ready` high at a clock edge, with no load) adds one to the 16-bit address, wrapping 0xFFFF to 0x0000. The page value stays unchanged, so `phys_addr` stays inside its 64 KB or 128 KB window.
- R4: A programmed count of N allows exactly N+1 accepted transfers, so 0 means one transfer and 0xFFFF means 65536. `xfer_ready` then falls in the cycle after the last accepted transfer.
- R5: `term_count` is high for exactly one cycle: the cycle after the accepted transfer that moves the count from 0x0000 to 0xFFFF.
- R6: After terminal count and until the next load, `xfer_valid` is ignored: `xfer_ready` stays low and `phys_addr` does not change.
- R7: A `load` copies `ld_addr`, `ld_count` and `ld_page` into the engine, clears the terminal-count state and raises `xfer_ready` in the next cycle. A load takes priority over a transfer in the same cycle.
- R8: During and after reset, before any load, `xfer_ready` and `term_count` are low and `phys_addr` is zero.
- R9: `byte_en` is 2'b01 for an even address and 2'b10 for an odd address on a byte channel. It is always 2'b11 on a word channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Copy programmed values into the engine |
| ld_addr | input | 16 | Programmed start address (bytes or words) |
| ld_count | input | 16 | Programmed transfer count minus one |
| ld_page | input | 8 | Programmed page value |
| xfer_valid | input | 1 | Requester offers a transfer |
| xfer_ready | output | 1 | Engine can accept a transfer |
| phys_addr | output | 24 | Physical address of the current transfer |
| byte_en | output | 2 | Active byte lanes of the current transfer |
| term_count | output | 1 | One-cycle pulse after the final transfer |

## Verification
The assertions assume three things about the inputs. `load` is a single-cycle command. Reset leaves the engine idle. The requester may drop `xfer_valid` at any time, because the engine never relies on it being held. Stepping properties are qualified by an accepted handshake with no load, so any mix of gaps, loads during a run and strobes after terminal count keeps within them. The stimulus covers one-transfer and full 65536-transfer runs, windows that wrap across 0xFFFF, odd page values, loads that land on a handshake, and valid strobes held after terminal count. Two channels, one byte and one word, receive identical stimulus.

// File: rtl/dma_xe_pkg.sv
package dma_xe_pkg;
  typedef enum logic {CHAN_BYTE = 1'b0, CHAN_WORD = 1'b1} chan_kind_e;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned PAGE_W = 8;
endpackage

// File: rtl/dma_xe_addr_ctr.sv
module dma_xe_addr_ctr #(
  parameter int unsigned ADDR_W = dma_xe_pkg::ADDR_W,
  parameter int unsigned PAGE_W = dma_xe_pkg::PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [PAGE_W-1:0] ld_page,
  output logic [ADDR_W-1:0] addr_q,
  output logic [PAGE_W-1:0] page_q
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      page_q <= '0;
    end else if (load) begin
      addr_q <= ld_addr;
      page_q <= ld_page;
    end else if (step) begin
      addr_q <= addr_q + ONE;
    end
  end

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr_q == $past(addr_q) + ONE));
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(page_q));
  p_load_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_q == $past(ld_addr) && page_q == $past(ld_page)));
endmodule

// File: rtl/dma_xe_count_ctr.sv
module dma_xe_count_ctr #(
  parameter int unsigned CNT_W = dma_xe_pkg::ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] ld_count,
  output logic             done_q,
  output logic             tc_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
      tc_q   <= 1'b0;
    end else if (load) begin
      cnt_q  <= ld_count;
      done_q <= 1'b0;
      tc_q   <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_q - ONE;
      done_q <= last;
      tc_q   <= last;
    end else begin
      tc_q   <= 1'b0;
    end
  end

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == $past(cnt_q) - ONE));
  p_tc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);
  p_tc_after_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_q) |-> ($past(cnt_q) == '0 && done_q));
  p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!done_q && !tc_q));
endmodule

// File: rtl/dma_xe_phys_map.sv
module dma_xe_phys_map
  import dma_xe_pkg::*;
#(
  parameter chan_kind_e  CHAN_KIND = CHAN_BYTE,
  parameter int unsigned ADDR_W    = dma_xe_pkg::ADDR_W,
  parameter int unsigned PAGE_W    = dma_xe_pkg::PAGE_W,
  localparam int unsigned PHYS_W   = ADDR_W + PAGE_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  output logic [PHYS_W-1:0] phys,
  output logic [1:0]        lanes
);
  localparam bit IS_WORD = (CHAN_KIND == CHAN_WORD);

  always_comb begin
    if (IS_WORD) phys = {page[PAGE_W-1:1], addr, 1'b0};
    else         phys = {page[PAGE_W-1:1], page[0], addr};
  end

  generate
    if (CHAN_KIND == CHAN_WORD) begin : g_word
      assign lanes = 2'b11;
    end else begin : g_byte
      assign lanes = {addr[0], ~addr[0]};
    end
  endgenerate
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xe_pkg::*;
#(
  parameter chan_kind_e CHAN_KIND = CHAN_BYTE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  logic [ADDR_W-1:0]    ld_count,
  input  logic [PAGE_W-1:0]    ld_page,
  input  logic                 xfer_valid,
  output logic                 xfer_ready,
  output logic [ADDR_W+PAGE_W-1:0] phys_addr,
  output logic [1:0]           byte_en,
  output logic                 term_count
);
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] page_q;
  logic              done_q;
  logic              step;

  assign xfer_ready = ~done_q;
  assign step       = xfer_valid & xfer_ready;

  dma_xe_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .ld_addr(ld_addr), .ld_page(ld_page),
    .addr_q(addr_q), .page_q(page_q)
  );

  dma_xe_count_ctr #(.CNT_W(ADDR_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .ld_count(ld_count), .done_q(done_q), .tc_q(term_count)
  );

  dma_xe_phys_map #(.CHAN_KIND(CHAN_KIND), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
    .addr(addr_q), .page(page_q), .phys(phys_addr), .lanes(byte_en)
  );

  p_tc_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    term_count |-> !xfer_ready);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ready && !load) |=> ($stable(phys_addr) && !xfer_ready));
  p_load_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> xfer_ready);
endmodule

// File: tb/dma_xfer_engine_tb.sv
`timescale 1ns/1ps
module dma_xfer_engine_tb;
  import dma_xe_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [15:0] ld_count = '0;
  logic [7:0]  ld_page = '0;
  logic        xfer_valid = 1'b0;

  logic        rdy_b, rdy_w, tc_b, tc_w;
  logic [23:0] pa_b, pa_w;
  logic [1:0]  be_b, be_w;

  always #2.5 clk = ~clk;

  dma_xfer_engine #(.CHAN_KIND(CHAN_BYTE)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr), .ld_count(ld_count),
    .ld_page(ld_page), .xfer_valid(xfer_valid), .xfer_ready(rdy_b),
    .phys_addr(pa_b), .byte_en(be_b), .term_count(tc_b));

  dma_xfer_engine #(.CHAN_KIND(CHAN_WORD)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr), .ld_count(ld_count),
    .ld_page(ld_page), .xfer_valid(xfer_valid), .xfer_ready(rdy_w),
    .phys_addr(pa_w), .byte_en(be_w), .term_count(tc_w));

  // reference state
  logic [15:0] m_addr = '0, m_cnt = '0;
  logic [7:0]  m_page = '0;
  bit          m_done = 1'b1, m_tc = 1'b0;
  int vectors = 0, fails = 0;
  bit finished = 0;

  task automatic fail(string req, logic [31:0] act, logic [31:0] exp);
    fails++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic compare();
    logic [23:0] eb, ew;
    logic [1:0]  ebe;
    eb  = {m_page, m_addr};
    ew  = {m_page[7:1], m_addr, 1'b0};
    ebe = {m_addr[0], ~m_addr[0]};
    vectors++;
    if (pa_b !== eb)      fail("R1 byte phys_addr", 32'(pa_b), 32'(eb));
    if (pa_w !== ew)      fail("R2 word phys_addr", 32'(pa_w), 32'(ew));
    if (rdy_b !== !m_done) fail("R4 byte xfer_ready", 32'(rdy_b), 32'(!m_done));
    if (rdy_w !== !m_done) fail("R4 word xfer_ready", 32'(rdy_w), 32'(!m_done));
    if (tc_b !== m_tc)    fail("R5 byte term_count", 32'(tc_b), 32'(m_tc));
    if (tc_w !== m_tc)    fail("R5 word term_count", 32'(tc_w), 32'(m_tc));
    if (be_b !== ebe)     fail("R9 byte byte_en", 32'(be_b), 32'(ebe));
    if (be_w !== 2'b11)   fail("R9 word byte_en", 32'(be_w), 32'h3);
  endtask

  // compare current outputs at negedge, then drive and advance the model
  task automatic step(bit ld, logic [15:0] a, logic [15:0] c, logic [7:0] p, bit v);
    bit hs;
    @(negedge clk);
    compare();
    load = ld; ld_addr = a; ld_count = c; ld_page = p; xfer_valid = v;
    hs = v && !m_done;
    if (ld) begin
      m_addr = a; m_cnt = c; m_page = p; m_done = 0; m_tc = 0;
    end else if (hs) begin
      m_tc = (m_cnt == 16'h0);
      if (m_cnt == 16'h0) m_done = 1;
      m_addr = m_addr + 16'd1;
      m_cnt  = m_cnt - 16'd1;
    end else begin
      m_tc = 0;
    end
  endtask

  task automatic run(int cycles, int gap_pct);
    for (int i = 0; i < cycles; i++)
      step(0, '0, '0, '0, ($urandom_range(99) >= gap_pct));
  endtask

  initial begin
    // R8: reset state
    repeat (3) step(0, '0, '0, '0, 1);
    @(negedge clk); rst_n = 1'b1;
    step(0, '0, '0, '0, 1);               // R8: strobe before load ignored
    // R4 R5: count 0 means one transfer; odd page checks R2
    step(1, 16'h1234, 16'h0000, 8'h5B, 0);
    step(0, '0, '0, '0, 1);
    // R6: strobes held after terminal count
    run(6, 0);
    // R3: wrap inside window, page unchanged
    step(1, 16'hFFFE, 16'h0003, 8'h81, 1);
    run(8, 0);
    // R7: load coinciding with a handshake mid-run
    step(1, 16'h0100, 16'h0010, 8'h22, 1);
    run(4, 0);
    step(1, 16'h7FFF, 16'h0005, 8'hC3, 1);
    run(12, 30);
    // R9 R1 R2: gappy run with odd and even addresses
    step(1, 16'h0033, 16'h00FF, 8'hA7, 0);
    run(400, 40);
    // R3 R4: long run across the window wrap
    step(1, 16'hFF80, 16'h01FF, 8'hFF, 0);
    run(530, 5);
    // R4: maximum count 0xFFFF gives 65536 transfers
    step(1, 16'h0000, 16'hFFFF, 8'h01, 0);
    run(65540, 0);
    step(0, '0, '0, '0, 0);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule